// File: doc/BRIEF.md
# Single-Digit Decimal Up/Down Counter

This block counts one decimal digit, 0 through 9, in either direction. Its state is a 4-bit register that holds the digit as a plain binary number. That register drives the count output directly, so no decoding stage sits between the state and the output pins.

A clock-enable input gates the counting. A direction input picks up or down, and a synchronous load copies a data word into the state. An active-low clear forces the digit to zero at once, without waiting for a clock edge.

A terminal-count output rises while the digit is about to roll over in the selected direction. This lets a row of these counters form a multi-digit decimal counter: each digit's terminal count drives the enable of the next, more significant digit.

Top module: `bcd_digit_counter`

## Requirements
- R1: While `clr_n` is 0 at a rising clock edge, the next value of `q` is 0.
- R2: Driving `clr_n` to 0 sets `q` to 0 at once, with no clock edge in between.
- R3: With `load` = 0 and `cnt_en` = 0, a clock edge leaves `q` unchanged.
- R4: With `load` = 0, `cnt_en` = 1 and `up_dn` = 1 (up), a clock edge moves a digit 0..8 to the digit plus one.
- R5: In up mode with counting enabled and no load, 9 goes to 0 on the next edge.
- R6: With `load` = 0, `cnt_en` = 1 and `up_dn` = 0 (down), a clock edge moves a digit 1..9 to the digit minus one.
- R7: In down mode with counting enabled and no load, 0 goes to 9 on the next edge.
- R8: With `load` = 1, the next edge copies `din` into `q`, whatever the values of `cnt_en` and `up_dn`. All 16 codes of `din` are accepted.
- R9: If `q` holds an illegal code (10 to 15), the next counting step (`cnt_en` = 1, `load` = 0) sets it to 0 in either direction.
- R10: `tc` is 1 when `cnt_en` = 1, `up_dn` = 1 and `q` = 9.
- R11: `tc` is 1 when `cnt_en` = 1, `up_dn` = 0 and `q` = 0.
- R12: In every other case `tc` is 0, and in particular whenever `cnt_en` = 0. `tc` does not depend on `load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low; forces the digit to 0 |
| cnt_en | input | 1 | Count enable |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| load | input | 1 | Synchronous parallel load, takes priority over counting |
| din | input | 4 | Value loaded when `load` is 1 |
| q | output | 4 | Current digit, a copy of the state register |
| tc | output | 1 | Terminal count for driving the next digit's enable |

## Verification
Properties checked on every clock cycle:
- The hold with counting disabled.
- Both wrap points: 9 to 0 going up, 0 to 9 going down.
- The load path.
- The rule that the digit is legal after every counting step with no load.

Other behaviours are shown only by the bench scenarios:
- The clear acting between clock edges.
- Recovery from illegal codes 10 to 15 loaded through `din`.
- The combinational value of `tc` under every mix of enable and direction.

In those scenarios, the bench compares both outputs against its own modulo-10 model, under seeded random mixes of load, enable and direction.

// File: rtl/bcd_pkg.sv
// Shared types for the decimal digit counter.
// Assumes: the control inputs are synchronous to the counter clock.
package bcd_pkg;

    // Count direction as carried on the up_dn pin.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Control bundle presented to the next-state and terminal-count logic.
    typedef struct packed {
        logic load;
        logic en;
        dir_e dir;
    } ctrl_t;

endpackage

// File: rtl/bcd_state_reg.sv
// State register: W flip-flops in parallel with an asynchronous active-low clear.
// Assumes: clr_n is released away from the rising clock edge.
module bcd_state_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the next state, or clear at once when clr_n falls.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/bcd_next_state.sv
// Next-state logic: load, hold, and modulo-MODULUS count in either direction.
// Codes at or above MODULUS go to zero on any counting step.
// Assumes: MODULUS >= 2 and MODULUS <= 2**W.
module bcd_next_state
    import bcd_pkg::*;
#(
    parameter int W       = 4,
    parameter int MODULUS = 10
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    input  ctrl_t        ctrl,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    logic [W-1:0] inc_val;
    logic [W-1:0] dec_val;

    // Successor going up: wrap at the top and send illegal codes to zero.
    always_comb begin
        if (cur >= TOP) inc_val = '0;
        else            inc_val = cur + 1'b1;
    end

    // Successor going down: wrap at zero and send illegal codes to zero.
    always_comb begin
        if (cur == '0)      dec_val = TOP;
        else if (cur > TOP) dec_val = '0;
        else                dec_val = cur - 1'b1;
    end

    // Pick the next state; load wins over count, count wins over hold.
    always_comb begin
        if (ctrl.load)             nxt = din;
        else if (!ctrl.en)         nxt = cur;
        else if (ctrl.dir == DIR_UP) nxt = inc_val;
        else                       nxt = dec_val;
    end

endmodule

// File: rtl/bcd_term_count.sv
// Terminal count: flags that the enabled digit is at its rollover point in the
// selected direction, so a more significant digit can use it as its enable.
// Assumes: the flag is independent of the load input.
module bcd_term_count
    import bcd_pkg::*;
#(
    parameter int W       = 4,
    parameter int MODULUS = 10
) (
    input  logic [W-1:0] cur,
    input  ctrl_t        ctrl,
    output logic         tc
);

    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    // Compare the state with the edge value for the selected direction.
    always_comb begin
        if (!ctrl.en)                tc = 1'b0;
        else if (ctrl.dir == DIR_UP) tc = (cur == TOP);
        else                         tc = (cur == '0);
    end

endmodule

// File: rtl/bcd_digit_counter.sv
// Single decimal digit up/down counter with synchronous load, asynchronous
// clear and a terminal count for cascading. The output is the raw state.
// Assumes: all inputs other than clr_n are synchronous to clk.
module bcd_digit_counter
    import bcd_pkg::*;
#(
    parameter int W       = 4,
    parameter int MODULUS = 10
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         cnt_en,
    input  logic         up_dn,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc
);

    localparam logic [W-1:0] TOP = W'(MODULUS - 1);

    ctrl_t        ctrl;
    logic [W-1:0] state;
    logic [W-1:0] nxt;

    // Bundle the control pins for the combinational blocks.
    always_comb begin
        ctrl.load = load;
        ctrl.en   = cnt_en;
        ctrl.dir  = dir_e'(up_dn);
    end

    bcd_next_state #(.W(W), .MODULUS(MODULUS)) u_next (
        .cur  (state),
        .din  (din),
        .ctrl (ctrl),
        .nxt  (nxt)
    );

    bcd_state_reg #(.W(W)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (nxt),
        .q     (state)
    );

    bcd_term_count #(.W(W), .MODULUS(MODULUS)) u_tc (
        .cur  (state),
        .ctrl (ctrl),
        .tc   (tc)
    );

    // The output is a plain copy of the state register.
    assign q = state;

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && !cnt_en) |=> $stable(q));

    // R5
    up_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && cnt_en && up_dn && q == TOP) |=> (q == '0));

    // R7
    down_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && cnt_en && !up_dn && q == '0) |=> (q == TOP));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        load |=> (q == $past(din)));

    // R9
    legal_after_count_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!load && cnt_en) |=> (q <= TOP));

endmodule

// File: tb/test_bcd_digit_counter.sv
// Self-checking bench: directed corner cases plus seeded random stimulus,
// compared with a modulo-10 reference model.
module test_bcd_digit_counter;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic       up_dn = 1'b1;
    logic       load = 1'b0;
    logic [3:0] din = 4'd0;
    logic [3:0] q;
    logic       tc;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_q = 4'd0;

    localparam time PERIOD = 10ns;

    always #(PERIOD/2) clk = ~clk;

    bcd_digit_counter i_bcd_digit_counter (
        .clk(clk), .clr_n(clr_n), .cnt_en(cnt_en), .up_dn(up_dn),
        .load(load), .din(din), .q(q), .tc(tc)
    );

    // Reference next digit.
    function automatic logic [3:0] model_next(logic [3:0] cur, logic ce,
                                              logic up, logic ld, logic [3:0] d);
        if (ld) return d;
        if (!ce) return cur;
        if (cur > 4'd9) return 4'd0;
        if (up) return (cur == 4'd9) ? 4'd0 : cur + 4'd1;
        return (cur == 4'd0) ? 4'd9 : cur - 4'd1;
    endfunction

    // Reference terminal count.
    function automatic logic model_tc(logic [3:0] cur, logic ce, logic up);
        if (!ce) return 1'b0;
        return up ? (cur == 4'd9) : (cur == 4'd0);
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock step: drive at the falling edge, check tc, then check q after the edge.
    task automatic step(logic ce, logic up, logic ld, logic [3:0] d, string qtag, string ttag);
        @(negedge clk);
        cnt_en = ce; up_dn = up; load = ld; din = d;
        #1;
        check(ttag, {3'b0, tc}, {3'b0, model_tc(exp_q, ce, up)});
        exp_q = model_next(exp_q, ce, up, ld, d);
        @(posedge clk);
        #1;
        check(qtag, q, exp_q);
    endtask

    initial begin : watchdog
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        // R1: clear held across edges
        repeat (3) @(posedge clk);
        #1 check("R1", q, 4'd0);
        @(negedge clk) clr_n = 1'b1;
        exp_q = 4'd0;

        // R3: hold with enable low
        step(1'b0, 1'b1, 1'b0, 4'd7, "R3", "R12");
        // R4, R5: full up sweep with wrap
        for (int i = 0; i < 9; i++) step(1'b1, 1'b1, 1'b0, 4'd0, "R4", "R12");
        check("R10", {3'b0, tc}, 4'd1);
        step(1'b1, 1'b1, 1'b0, 4'd0, "R5", "R10");
        // R7, R6: down wrap then full down sweep
        step(1'b1, 1'b0, 1'b0, 4'd0, "R7", "R11");
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 1'b0, 4'd0, "R6", "R12");
        #1 check("R11", {3'b0, tc}, 4'd1);
        // R12: enable low kills tc at the rollover point
        step(1'b0, 1'b0, 1'b0, 4'd0, "R3", "R12");
        // R8: load with enable low and high
        step(1'b0, 1'b1, 1'b1, 4'd6, "R8", "R12");
        step(1'b1, 1'b0, 1'b1, 4'd3, "R8", "R12");
        // R9: illegal codes recover in both directions
        step(1'b1, 1'b1, 1'b1, 4'd13, "R8", "R12");
        step(1'b1, 1'b1, 1'b0, 4'd0, "R9", "R12");
        step(1'b0, 1'b0, 1'b1, 4'd15, "R8", "R12");
        step(1'b0, 1'b0, 1'b0, 4'd0, "R3", "R12");
        step(1'b1, 1'b0, 1'b0, 4'd0, "R9", "R12");
        // R2: asynchronous clear between edges
        step(1'b0, 1'b1, 1'b1, 4'd8, "R8", "R12");
        @(negedge clk);
        load = 1'b0; cnt_en = 1'b0;
        #1 clr_n = 1'b0;
        #1 check("R2", q, 4'd0);
        @(negedge clk) clr_n = 1'b1;
        exp_q = 4'd0;

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic ce, up, ld;
            logic [3:0] d;
            string tg;
            ce = ($urandom % 4) != 0;
            up = $urandom % 2;
            ld = ($urandom % 8) == 0;
            d  = 4'($urandom % 16);
            if (ld)                tg = "R8";
            else if (!ce)          tg = "R3";
            else if (exp_q > 4'd9) tg = "R9";
            else if (up)           tg = "R4";
            else                   tg = "R6";
            step(ce, up, ld, d, tg, "R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule